// File: doc/BRIEF.md
# Dual-Mode Watchdog Supervisor

This block watches for a stalled processor by counting slow time ticks taken from a free-running watch counter. Software must restart the count often enough; if four ticks of the chosen source go by without a restart, the supervisor either requests a processor reset or raises an interrupt flag. The choice depends on a mode bit in its small control register. In interrupt mode the count keeps running after each expiry and flags again on every wrap, so the block also serves as a plain periodic timer.

The tick source is one of four single-cycle strobe taps from the watch counter. A tap is counted only while the watch-timer enable input is high. After reset the supervisor is running and set for reset mode. It still sees no ticks until the watch timer is enabled. When a selected source goes quiet, for example because its clock is stopped in a low-power state, the count pauses and keeps its value.

Top module: `wdog_supervisor`

## Requirements
- R1: After a synchronous reset, `cfg_q` reads 4'b1100 (bit 3 mode = 1 meaning reset mode, bit 2 run = 1, bits 1:0 source select = 0). `rst_req` and `irq_flag` are both 0.
- R2: While `wt_en` is 0, tap strobes are not counted. No expiry results from them, however many arrive.
- R3: Only strobes on `tick_taps[sel]` advance the count, where `sel` is bits 1:0 of `cfg_q`. Strobes on the other taps are ignored.
- R4: A write (`cfg_we` high) with bit 2 of `cfg_wdata` set to 1 clears the count and sets run. A write with bit 2 set to 0 clears run. While run is 0 the count holds and strobes are ignored. Bits 3 and 1:0 of the write load mode and select.
- R5: Expiry occurs on the fourth counted strobe after a clear, when the 2-bit count wraps from 3 to 0.
- R6: On expiry with mode = 1, `rst_req` rises in the cycle after the fourth strobe is sampled. It stays high for exactly 4 clock cycles and then falls. An expiry while the pulse is active starts no new pulse.
- R7: The same edge that starts a reset pulse returns the control register to its reset value 4'b1100.
- R8: On expiry with mode = 0, `irq_flag` is set in the cycle after the fourth strobe and `rst_req` stays 0. The flag holds until `irq_clr` is high. Counting continues, so every further fourth strobe sets the flag again.
- R9: Gaps of any length between strobes of the selected source leave the count unchanged. Expiry still follows the fourth strobe in total.
- R10: When a write with bit 2 = 1 lands in the same cycle as a selected strobe, the clear wins and that strobe is not counted.
- R11: When an expiry in mode 0 and `irq_clr` fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_en | input | 1 | Watch timer enable; gates all taps |
| tick_taps | input | 4 | Single-cycle tick strobes, one per watch-counter tap |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Write data: bit 3 mode, bit 2 clear/start, bits 1:0 source |
| cfg_q | output | 4 | Control register contents: bit 3 mode, bit 2 run, bits 1:0 source |
| irq_clr | input | 1 | Clears the interrupt flag |
| rst_req | output | 1 | Registered processor reset request pulse |
| irq_flag | output | 1 | Registered sticky expiry interrupt flag |

## Verification
Two pairs of functions can fall in the same cycle. The first is a software restart and a counted tick. The bench brings the count to three, then drives a clear/start write on the same negative edge as a selected strobe. The restart is judged to have won when exactly four more strobes, and not one, produce the flag. The second pair is an interrupt-mode expiry and a flag clear. The bench drives `irq_clr` together with the fourth strobe and expects the flag to read 1 on the next sample.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Control register layout
  localparam int SEL_W    = 2;
  localparam int NUM_TAPS = 1 << SEL_W;
  localparam int CFG_W    = SEL_W + 2;
  localparam int RUN_BIT  = SEL_W;
  localparam int MODE_BIT = SEL_W + 1;

  typedef struct packed {
    logic             mode;  // 1: reset request, 0: interrupt
    logic             run;   // counting allowed
    logic [SEL_W-1:0] sel;   // tap select
  } wd_cfg_t;

  localparam wd_cfg_t CFG_DEFAULT = '{mode: 1'b1, run: 1'b1, sel: '0};

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             load_dflt,
  output wd_cfg_t          cfg,
  output logic             restart
);

  wd_cfg_t cfg_r;

  // A write with the start bit set restarts the count
  assign restart = we & wdata[RUN_BIT];

  always_ff @(posedge clk) begin
    if (rst || load_dflt) begin
      cfg_r <= CFG_DEFAULT;
    end else if (we) begin
      cfg_r.mode <= wdata[MODE_BIT];
      cfg_r.run  <= wdata[RUN_BIT];
      cfg_r.sel  <= wdata[SEL_W-1:0];
    end
  end

  assign cfg = cfg_r;

endmodule

// File: rtl/wdog_tick_mux.sv
module wdog_tick_mux #(
  parameter int NTAPS = 4,
  parameter int SW    = 2
) (
  input  logic [NTAPS-1:0] taps,
  input  logic [SW-1:0]    sel,
  input  logic             wt_en,
  output logic             tick
);

  logic [NTAPS-1:0] gated;

  genvar g;
  generate
    for (g = 0; g < NTAPS; g++) begin : g_gate
      assign gated[g] = taps[g] & wt_en;
    end
  endgenerate

  assign tick = gated[sel];

endmodule

// File: rtl/wdog_det_counter.sv
module wdog_det_counter #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          restart,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_r;
  logic          step;

  // Restart has priority over a coincident tick
  assign step = run & tick & ~restart;
  assign wrap = step & (cnt_r == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_r <= '0;
    end else if (step) begin
      cnt_r <= cnt_r + 1'b1;
    end
  end

  assign cnt = cnt_r;

endmodule

// File: rtl/wdog_out_steer.sv
module wdog_out_steer #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic mode,
  input  logic irq_clr,
  output logic launch,
  output logic rst_req,
  output logic irq_flag
);

  localparam int LW = $clog2(PULSE_LEN + 1);
  localparam logic [LW-1:0] LOAD_VAL = LW'(PULSE_LEN - 1);

  logic [LW-1:0] left_r;
  logic          rst_r;
  logic          irq_r;

  assign launch = wrap & mode & ~rst_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_r <= '0;
      rst_r  <= 1'b0;
    end else if (launch) begin
      left_r <= LOAD_VAL;
      rst_r  <= 1'b1;
    end else if (left_r != '0) begin
      left_r <= left_r - 1'b1;
    end else begin
      rst_r  <= 1'b0;
    end
  end

  // Set wins over clear
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_r <= 1'b0;
    end else if (wrap && !mode) begin
      irq_r <= 1'b1;
    end else if (irq_clr) begin
      irq_r <= 1'b0;
    end
  end

  assign rst_req  = rst_r;
  assign irq_flag = irq_r;

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 2,
  parameter int RST_LEN = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wt_en,
  input  logic [NUM_TAPS-1:0] tick_taps,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_q,
  input  logic                irq_clr,
  output logic                rst_req,
  output logic                irq_flag
);

  wd_cfg_t          cfg;
  logic             restart;
  logic             tick;
  logic             wrap;
  logic             launch;
  logic [CNT_W-1:0] cnt_q;

  wdog_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .load_dflt (launch),
    .cfg       (cfg),
    .restart   (restart)
  );

  wdog_tick_mux #(.NTAPS(NUM_TAPS), .SW(SEL_W)) u_mux (
    .taps  (tick_taps),
    .sel   (cfg.sel),
    .wt_en (wt_en),
    .tick  (tick)
  );

  wdog_det_counter #(.CW(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (cfg.run),
    .tick    (tick),
    .restart (restart),
    .cnt     (cnt_q),
    .wrap    (wrap)
  );

  wdog_out_steer #(.PULSE_LEN(RST_LEN)) u_out (
    .clk      (clk),
    .rst      (rst),
    .wrap     (wrap),
    .mode     (cfg.mode),
    .irq_clr  (irq_clr),
    .launch   (launch),
    .rst_req  (rst_req),
    .irq_flag (irq_flag)
  );

  assign cfg_q = cfg;

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 2,
  parameter int RST_LEN = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wt_en,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_q,
  input logic             irq_clr,
  input logic             rst_req,
  input logic             irq_flag,
  input logic [CNT_W-1:0] cnt_q
);

  localparam int HW = $clog2(RST_LEN + 2);
  logic [HW-1:0] hi_len;

  always_ff @(posedge clk) begin
    if (rst || !rst_req) hi_len <= '0;
    else                 hi_len <= hi_len + 1'b1;
  end

  // R6: pulse never longer than RST_LEN cycles
  assert_pulse_max_R6: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (hi_len < HW'(RST_LEN)));

  // R6: pulse ends exactly after RST_LEN cycles
  assert_pulse_exact_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_req) |-> (hi_len == HW'(RST_LEN)));

  // R7: control register at default when a pulse starts
  assert_cfg_default_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> (cfg_q == CFG_W'(CFG_DEFAULT)));

  // R8: flag sticky until cleared
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_clr) |=> irq_flag);

  // R8: one expiry never raises both outputs
  assert_single_output_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> !$rose(rst_req));

  // R2: no counting while watch timer disabled
  assert_gate_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!wt_en && !cfg_we) |=> $stable(cnt_q));

endmodule

bind wdog_supervisor wdog_supervisor_chk #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wt_en    (wt_en),
  .cfg_we   (cfg_we),
  .cfg_q    (cfg_q),
  .irq_clr  (irq_clr),
  .rst_req  (rst_req),
  .irq_flag (irq_flag),
  .cnt_q    (cnt_q)
);

// File: tb/test_wdog_supervisor.sv
module test_wdog_supervisor;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wt_en = 1'b0;
  logic [3:0] tick_taps = '0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic [3:0] cfg_q;
  logic       irq_clr = 1'b0;
  logic       rst_req;
  logic       irq_flag;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdog_supervisor i_wdog_supervisor (
    .clk(clk), .rst(rst), .wt_en(wt_en), .tick_taps(tick_taps),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .irq_clr(irq_clr), .rst_req(rst_req), .irq_flag(irq_flag)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int tap);
    @(negedge clk) tick_taps = 4'(1 << tap);
    @(negedge clk) tick_taps = '0;
  endtask

  task automatic ticks(int tap, int n);
    for (int i = 0; i < n; i++) tick(tap);
  endtask

  task automatic wr(logic [3:0] d);
    @(negedge clk) begin cfg_we = 1'b1; cfg_wdata = d; end
    @(negedge clk) cfg_we = 1'b0;
  endtask

  task automatic clr_irq();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  // Called at the sample right after the expiring tick
  task automatic chk_pulse(string req);
    for (int i = 0; i < 5; i++) begin
      check(req, 8'(rst_req), (i < 4) ? 8'd1 : 8'd0);
      if (i < 4) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 cfg", 8'(cfg_q), 8'hC);
    check("R1 rst_req", 8'(rst_req), 8'd0);
    check("R1 irq", 8'(irq_flag), 8'd0);
  endtask

  task automatic t_gate();
    wt_en = 1'b0;
    ticks(0, 6);
    check("R2 no expiry while gated", 8'(rst_req), 8'd0);
    wt_en = 1'b1;
    ticks(0, 3);
    check("R5 three ticks", 8'(rst_req), 8'd0);
    tick(0);
    chk_pulse("R6 pulse after fourth tick");
  endtask

  task automatic t_select();
    wr(4'b1110);
    check("R4 cfg loaded", 8'(cfg_q), 8'hE);
    ticks(0, 4); ticks(1, 4); ticks(3, 4);
    check("R3 other taps ignored", 8'(rst_req), 8'd0);
    ticks(2, 3);
    check("R3 three on selected", 8'(rst_req), 8'd0);
    tick(2);
    check("R7 cfg back to default", 8'(cfg_q), 8'hC);
    chk_pulse("R6 pulse via tap 2");
    ticks(0, 3);
    check("R7 count cleared", 8'(rst_req), 8'd0);
    tick(0);
    chk_pulse("R7 fresh count expires");
  endtask

  task automatic t_stop();
    wr(4'b1100);
    ticks(0, 2);
    wr(4'b1000);
    check("R4 run cleared", 8'(cfg_q), 8'h8);
    ticks(0, 5);
    check("R4 stopped ignores ticks", 8'(rst_req), 8'd0);
    wr(4'b1100);
    ticks(0, 3);
    check("R4 restart clears count", 8'(rst_req), 8'd0);
    repeat (25) @(negedge clk);
    check("R9 gap holds", 8'(rst_req), 8'd0);
    tick(0);
    chk_pulse("R9 expiry after gap");
  endtask

  task automatic t_irq();
    wr(4'b0100);
    ticks(0, 4);
    check("R8 flag set", 8'(irq_flag), 8'd1);
    check("R8 no reset", 8'(rst_req), 8'd0);
    ticks(0, 3);
    check("R8 flag holds", 8'(irq_flag), 8'd1);
    clr_irq();
    check("R8 flag cleared", 8'(irq_flag), 8'd0);
    tick(0);
    check("R8 re-flag on wrap", 8'(irq_flag), 8'd1);
    clr_irq();
    ticks(0, 3);
    @(negedge clk) begin tick_taps = 4'b0001; irq_clr = 1'b1; end
    @(negedge clk) begin tick_taps = '0; irq_clr = 1'b0; end
    check("R11 set wins over clear", 8'(irq_flag), 8'd1);
    check("R8 still no reset", 8'(rst_req), 8'd0);
  endtask

  task automatic t_race();
    clr_irq();
    wr(4'b0100);
    ticks(0, 3);
    @(negedge clk) begin tick_taps = 4'b0001; cfg_we = 1'b1; cfg_wdata = 4'b0100; end
    @(negedge clk) begin tick_taps = '0; cfg_we = 1'b0; end
    check("R10 clear beats tick", 8'(irq_flag), 8'd0);
    ticks(0, 3);
    check("R10 tick not counted", 8'(irq_flag), 8'd0);
    tick(0);
    check("R10 expiry after four", 8'(irq_flag), 8'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gate();
    t_select();
    t_stop();
    t_irq();
    t_race();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule